// File: doc/BRIEF.md
# ISA I/O Address Window Translator

This block sits between a big-endian processor's memory-mapped access path and a little-endian ISA-style I/O port bus. Every processor request is tested against an 8 MB physical window starting at 0x8000_0000. A request that lands inside the window is turned into a 16-bit I/O port address and issued as a one-cycle port strobe. A request outside the window produces no strobe.

Two mapping modes are supported, selected by a single map-type bit that software loads. In the contiguous mode, the first 64 KB of the window map one-to-one onto the port space. In the sparse mode, each group of 32 ports occupies its own 4 KB page of the window, so that every group can be protected on its own page. The translator folds the page number down next to the 5-bit in-page offset, which packs the sparse pages into the dense port space.

Data crossing the block is converted between processor byte order and bus byte order. Write data goes towards the bus, and read data returning from the bus goes back towards the processor. All outputs are registered and appear one clock after the request or bus response. The bus-cycle sequencing itself is handled elsewhere.

Top module: `isa_io_window`

## Requirements
- R1: One clock after each cycle with `req_valid` high, `acc_valid` is 1. `acc_hit` is 1 exactly when `req_addr` lies in [0x8000_0000, 0x8080_0000). Both are 0 one clock after a cycle without a request.
- R2: `io_valid` pulses only one clock after a request that hits the window, and never after a miss. On a hit, `io_write` and `io_size` carry the request's direction and size code.
- R3: With `map_mode` = 0, the port address is window offset bits [15:0].
- R4: With `map_mode` = 1, the port address is {offset[22:12], offset[4:0]}. Offset bits [11:5] are ignored.
- R5: `map_mode` is 0 after reset. It loads `cfg_sparse` on a cycle with `cfg_we` high and holds otherwise. A request in the same cycle as the load still uses the old mode.
- R6: Size code 0 (byte) passes data bits [7:0] unchanged and zeroes bits [31:8].
- R7: Size code 1 (16-bit) swaps bytes [7:0] and [15:8] and zeroes bits [31:16].
- R8: Size codes 2 and 3 (32-bit) reverse all four bytes.
- R9: One clock after `isa_rvalid`, `cpu_rvalid` is 1. `cpu_rdata` is then `isa_rdata` converted by the R6–R8 rule for the size of the most recent read that hit the window (byte if none). When `cpu_rvalid` is 0, `cpu_rdata` is 0.
- R10: While reset is held, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 16-bit, 2/3 32-bit |
| req_addr | input | 32 | Processor physical address |
| req_wdata | input | 32 | Write data in processor order |
| cfg_we | input | 1 | Load the map-type bit |
| cfg_sparse | input | 1 | New map-type bit value |
| isa_rvalid | input | 1 | Bus read data valid |
| isa_rdata | input | 32 | Bus read data in bus order |
| acc_valid | output | 1 | A request was seen last cycle |
| acc_hit | output | 1 | Last request fell in the window |
| io_valid | output | 1 | Port access strobe |
| io_write | output | 1 | Port access direction |
| io_size | output | 2 | Port access size code |
| io_addr | output | 16 | Translated port address |
| io_wdata | output | 32 | Write data in bus order |
| cpu_rvalid | output | 1 | Read data for the processor valid |
| cpu_rdata | output | 32 | Read data in processor order |
| map_mode | output | 1 | Current map-type bit |

## Verification
The bench targets the window edges at 0x7FFF_FFFF, 0x8000_0000, 0x807F_FFFF and 0x8080_0000. An off-by-one compare would strobe a port for a foreign address or drop the last valid one. It also issues sparse-mode requests with junk in offset bits [11:5], which a wrong shift would leak into the port number. It exercises a mode load coinciding with a request, where a design using the new bit a cycle early would translate that request in the wrong mode. Read responses are made to follow reads of different sizes, so that a converter keyed to the current request instead of the last hitting read, or one that forgets to clear the upper lanes on narrow accesses, returns wrong bytes.

// File: rtl/isa_win_pkg.sv
package isa_win_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

endpackage

// File: rtl/isa_win_decode.sv
module isa_win_decode #(
    parameter int                ADDR_W   = 32,
    parameter int                WIN_LOG2 = 23,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8000_0000
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic                in_win,
    output logic [WIN_LOG2-1:0] offset
);
    localparam int TAG_W = ADDR_W - WIN_LOG2;
    localparam logic [TAG_W-1:0] BASE_TAG = WIN_BASE[ADDR_W-1:WIN_LOG2];

    // base is window-aligned, so the offset is the low address bits
    always_comb begin
        in_win = (addr[ADDR_W-1:WIN_LOG2] == BASE_TAG);
        offset = addr[WIN_LOG2-1:0];
    end
endmodule

// File: rtl/isa_win_addr_map.sv
module isa_win_addr_map #(
    parameter int WIN_LOG2   = 23,
    parameter int PORT_W     = 16,
    parameter int PAGE_SHIFT = 12,
    parameter int LOW_BITS   = 5
) (
    input  logic [WIN_LOG2-1:0] offset,
    input  logic                sparse,
    output logic [PORT_W-1:0]   port
);
    localparam int PAGE_BITS = WIN_LOG2 - PAGE_SHIFT;
    localparam int SPARSE_W  = PAGE_BITS + LOW_BITS;

    logic [SPARSE_W-1:0] packed_addr;
    logic [PORT_W-1:0]   sparse_port;
    logic [PORT_W-1:0]   dense_port;

    // page number slides down to sit directly above the in-page offset
    assign packed_addr = {offset[WIN_LOG2-1:PAGE_SHIFT], offset[LOW_BITS-1:0]};
    assign dense_port  = offset[PORT_W-1:0];

    generate
        if (SPARSE_W >= PORT_W) begin : g_trunc
            assign sparse_port = packed_addr[PORT_W-1:0];
        end else begin : g_extend
            assign sparse_port = {{(PORT_W-SPARSE_W){1'b0}}, packed_addr};
        end
    endgenerate

    assign port = sparse ? sparse_port : dense_port;
endmodule

// File: rtl/isa_win_lane_swap.sv
module isa_win_lane_swap
    import isa_win_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] din,
    input  acc_size_e               size,
    output logic [LANES*LANE_W-1:0] dout
);
    localparam int HALF_N = (LANES < 2) ? LANES : 2;

    logic [LANES-1:0][LANE_W-1:0] din_l;
    logic [LANES-1:0][LANE_W-1:0] dout_l;

    assign din_l = din;
    assign dout  = dout_l;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            if (g < HALF_N) begin : g_low
                assign dout_l[g] = (size == SZ_BYTE) ? ((g == 0) ? din_l[0] : '0)
                                 : (size == SZ_HALF) ? din_l[HALF_N-1-g]
                                 : din_l[LANES-1-g];
            end else begin : g_high
                assign dout_l[g] = (size == SZ_BYTE || size == SZ_HALF) ? '0
                                 : din_l[LANES-1-g];
            end
        end
    endgenerate
endmodule

// File: rtl/isa_io_window.sv
module isa_io_window
    import isa_win_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                DATA_W     = 32,
    parameter int                WIN_LOG2   = 23,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h8000_0000,
    parameter int                PORT_W     = 16,
    parameter int                PAGE_SHIFT = 12,
    parameter int                LOW_BITS   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cfg_we,
    input  logic              cfg_sparse,
    input  logic              isa_rvalid,
    input  logic [DATA_W-1:0] isa_rdata,
    output logic              acc_valid,
    output logic              acc_hit,
    output logic              io_valid,
    output logic              io_write,
    output logic [1:0]        io_size,
    output logic [PORT_W-1:0] io_addr,
    output logic [DATA_W-1:0] io_wdata,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              map_mode
);
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;

    typedef struct packed {
        logic              acc_valid;
        logic              acc_hit;
        logic              io_valid;
        logic              io_write;
        logic [1:0]        io_size;
        logic [PORT_W-1:0] io_addr;
        logic [DATA_W-1:0] io_wdata;
        logic              cpu_rvalid;
        logic [DATA_W-1:0] cpu_rdata;
        logic              mode;
        logic [1:0]        rd_size;
    } state_t;

    state_t st_d, st_q;

    logic                in_win;
    logic [WIN_LOG2-1:0] win_off;
    logic [PORT_W-1:0]   port_c;
    logic [DATA_W-1:0]   wswap_c;
    logic [DATA_W-1:0]   rswap_c;

    isa_win_decode #(
        .ADDR_W  (ADDR_W),
        .WIN_LOG2(WIN_LOG2),
        .WIN_BASE(WIN_BASE)
    ) u_decode (
        .addr  (req_addr),
        .in_win(in_win),
        .offset(win_off)
    );

    isa_win_addr_map #(
        .WIN_LOG2  (WIN_LOG2),
        .PORT_W    (PORT_W),
        .PAGE_SHIFT(PAGE_SHIFT),
        .LOW_BITS  (LOW_BITS)
    ) u_map (
        .offset(win_off),
        .sparse(st_q.mode),
        .port  (port_c)
    );

    isa_win_lane_swap #(
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_wswap (
        .din (req_wdata),
        .size(acc_size_e'(req_size)),
        .dout(wswap_c)
    );

    isa_win_lane_swap #(
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_rswap (
        .din (isa_rdata),
        .size(acc_size_e'(st_q.rd_size)),
        .dout(rswap_c)
    );

    always_comb begin
        st_d           = st_q;
        st_d.acc_valid = req_valid;
        st_d.acc_hit   = req_valid && in_win;
        st_d.io_valid  = req_valid && in_win;
        if (req_valid) begin
            st_d.io_write = req_write;
            st_d.io_size  = req_size;
            st_d.io_addr  = port_c;
            st_d.io_wdata = wswap_c;
        end
        if (req_valid && in_win && !req_write) begin
            st_d.rd_size = req_size;
        end
        if (cfg_we) begin
            st_d.mode = cfg_sparse;
        end
        st_d.cpu_rvalid = isa_rvalid;
        st_d.cpu_rdata  = isa_rvalid ? rswap_c : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_valid  = st_q.acc_valid;
    assign acc_hit    = st_q.acc_hit;
    assign io_valid   = st_q.io_valid;
    assign io_write   = st_q.io_write;
    assign io_size    = st_q.io_size;
    assign io_addr    = st_q.io_addr;
    assign io_wdata   = st_q.io_wdata;
    assign cpu_rvalid = st_q.cpu_rvalid;
    assign cpu_rdata  = st_q.cpu_rdata;
    assign map_mode   = st_q.mode;
endmodule

// File: rtl/isa_io_window_chk.sv
module isa_io_window_chk #(
    parameter int                ADDR_W     = 32,
    parameter int                DATA_W     = 32,
    parameter int                WIN_LOG2   = 23,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h8000_0000,
    parameter int                PORT_W     = 16,
    parameter int                PAGE_SHIFT = 12,
    parameter int                LOW_BITS   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_size,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              cfg_we,
    input logic              isa_rvalid,
    input logic              acc_hit,
    input logic              io_valid,
    input logic [PORT_W-1:0] io_addr,
    input logic [DATA_W-1:0] io_wdata,
    input logic              cpu_rvalid,
    input logic              map_mode
);
    localparam logic [ADDR_W-WIN_LOG2-1:0] TAG = WIN_BASE[ADDR_W-1:WIN_LOG2];

    logic hit_c;
    assign hit_c = req_valid && (req_addr[ADDR_W-1:WIN_LOG2] == TAG);

    AST_HIT_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        hit_c |=> acc_hit); // R1
    AST_MISS_NOT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_c |=> !acc_hit); // R1
    AST_STROBE_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid |-> acc_hit); // R2
    AST_CONTIG_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_c && !map_mode) |=> io_addr == $past(req_addr[PORT_W-1:0])); // R3
    AST_SPARSE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_c && map_mode) |=>
        io_addr == {$past(req_addr[WIN_LOG2-1:PAGE_SHIFT]), $past(req_addr[LOW_BITS-1:0])}); // R4
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(map_mode)); // R5
    AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd0) |=>
        (io_wdata[DATA_W-1:8] == '0 && io_wdata[7:0] == $past(req_wdata[7:0]))); // R6
    AST_HALF_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd1) |=>
        (io_wdata[15:8] == $past(req_wdata[7:0]) && io_wdata[7:0] == $past(req_wdata[15:8]))); // R7
    AST_RD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        isa_rvalid |=> cpu_rvalid); // R9
endmodule

bind isa_io_window isa_io_window_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .WIN_LOG2  (WIN_LOG2),
    .WIN_BASE  (WIN_BASE),
    .PORT_W    (PORT_W),
    .PAGE_SHIFT(PAGE_SHIFT),
    .LOW_BITS  (LOW_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .cfg_we    (cfg_we),
    .isa_rvalid(isa_rvalid),
    .acc_hit   (acc_hit),
    .io_valid  (io_valid),
    .io_addr   (io_addr),
    .io_wdata  (io_wdata),
    .cpu_rvalid(cpu_rvalid),
    .map_mode  (map_mode)
);

// File: tb/isa_io_window_tb.sv
`timescale 1ns/1ps
module isa_io_window_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        cfg_we = 1'b0, cfg_sparse = 1'b0;
    logic        isa_rvalid = 1'b0;
    logic [31:0] isa_rdata = '0;
    logic        acc_valid, acc_hit, io_valid, io_write, cpu_rvalid, map_mode;
    logic [1:0]  io_size;
    logic [15:0] io_addr;
    logic [31:0] io_wdata, cpu_rdata;

    int n_chk = 0, n_bad = 0;
    logic       mode_m = 1'b0;
    logic [1:0] rdsz_m = 2'd0;

    always #2.5 clk = ~clk;

    isa_io_window u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_we(cfg_we), .cfg_sparse(cfg_sparse), .isa_rvalid(isa_rvalid),
        .isa_rdata(isa_rdata), .acc_valid(acc_valid), .acc_hit(acc_hit),
        .io_valid(io_valid), .io_write(io_write), .io_size(io_size),
        .io_addr(io_addr), .io_wdata(io_wdata), .cpu_rvalid(cpu_rvalid),
        .cpu_rdata(cpu_rdata), .map_mode(map_mode)
    );

    function automatic logic win(input logic [31:0] a);
        return a >= 32'h8000_0000 && a < 32'h8080_0000;
    endfunction

    function automatic logic [15:0] port_of(input logic [31:0] a, input logic m);
        return m ? {a[22:12], a[4:0]} : a[15:0];
    endfunction

    function automatic logic [31:0] conv(input logic [31:0] d, input logic [1:0] s);
        case (s)
            2'd0:    return {24'h0, d[7:0]};
            2'd1:    return {16'h0, d[7:0], d[15:8]};
            default: return {d[7:0], d[15:8], d[23:16], d[31:24]};
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic w, input logic [1:0] sz,
                        input logic [31:0] a, input logic [31:0] wd,
                        input logic cwe, input logic cbit,
                        input logic rv, input logic [31:0] rd);
        logic hit_e, mode_use;
        logic [1:0] rsz_use;
        req_valid = v; req_write = w; req_size = sz; req_addr = a; req_wdata = wd;
        cfg_we = cwe; cfg_sparse = cbit; isa_rvalid = rv; isa_rdata = rd;
        hit_e = v && win(a);
        mode_use = mode_m;
        rsz_use = rdsz_m;
        @(posedge clk);
        if (cwe) mode_m = cbit;
        if (hit_e && !w) rdsz_m = sz;
        @(negedge clk);
        chk("R1 acc_valid", 32'(acc_valid), 32'(v));
        chk("R1 acc_hit", 32'(acc_hit), 32'(hit_e));
        chk("R2 io_valid", 32'(io_valid), 32'(hit_e));
        if (hit_e) begin
            chk("R2 io_write", 32'(io_write), 32'(w));
            chk("R2 io_size", 32'(io_size), 32'(sz));
            chk(mode_use ? "R4 sparse port" : "R3 dense port",
                32'(io_addr), 32'(port_of(a, mode_use)));
            chk(sz == 2'd0 ? "R6 byte data" : (sz == 2'd1 ? "R7 half swap" : "R8 word swap"),
                io_wdata, conv(wd, sz));
        end
        chk("R5 map_mode", 32'(map_mode), 32'(mode_m));
        chk("R9 cpu_rvalid", 32'(cpu_rvalid), 32'(rv));
        chk("R9 cpu_rdata", cpu_rdata, rv ? conv(rd, rsz_use) : 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10: every output cleared while reset is held
        chk("R10 reset outputs",
            {16'(acc_valid), 8'(io_valid), 8'(cpu_rvalid)}, 32'h0);
        chk("R10 reset io_addr", 32'(io_addr), 32'h0);
        chk("R10 reset io_wdata", io_wdata, 32'h0);
        chk("R10 reset cpu_rdata", cpu_rdata, 32'h0);
        chk("R10 reset map_mode", 32'(map_mode), 32'h0);
        chk("R10 reset misc", {30'h0, acc_hit, io_write} | 32'(io_size), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2 window edges in dense mode (R3)
        step(1, 1, 2'd0, 32'h7FFF_FFFF, 32'h11, 0, 0, 0, 0);
        step(1, 1, 2'd0, 32'h8000_0000, 32'h22, 0, 0, 0, 0);
        step(1, 1, 2'd1, 32'h807F_FFFF, 32'hAABB, 0, 0, 0, 0);
        step(1, 1, 2'd0, 32'h8080_0000, 32'h33, 0, 0, 0, 0);
        step(0, 0, 2'd0, 32'h8000_0010, 32'h0, 0, 0, 0, 0);
        // R5: mode load with a request in the same cycle keeps the old mode
        step(1, 1, 2'd2, 32'h8012_3FE7, 32'h0102_0304, 1, 1, 0, 0);
        // R4: junk in offset bits [11:5] must be ignored
        step(1, 1, 2'd2, 32'h8012_3FE7, 32'h0102_0304, 0, 0, 0, 0);
        step(1, 1, 2'd1, 32'h807F_F01F, 32'hDEAD_BEEF, 0, 0, 0, 0);
        step(1, 1, 2'd3, 32'h8000_1FFF, 32'hCAFE_F00D, 0, 0, 0, 0);
        // R9: read responses keyed to the last hitting read size
        step(1, 0, 2'd1, 32'h8000_3002, 32'h0, 0, 0, 0, 0);
        step(1, 0, 2'd2, 32'h9000_0000, 32'h0, 0, 0, 1, 32'h1234_5678);
        step(1, 0, 2'd0, 32'h8000_4001, 32'h0, 0, 0, 1, 32'h8765_4321);
        step(0, 0, 2'd0, 32'h0, 32'h0, 0, 0, 1, 32'hA1B2_C3D4);
        step(0, 0, 2'd0, 32'h0, 32'h0, 1, 0, 0, 32'hFFFF_FFFF);
        step(1, 1, 2'd1, 32'h8000_BEEF, 32'h5566_7788, 0, 0, 0, 0);

        for (int i = 0; i < 600; i++) begin
            logic [31:0] a;
            case ($urandom % 8)
                0, 1, 2, 3: a = 32'h8000_0000 | ($urandom & 32'h007F_FFFF);
                4:          a = 32'h8000_0000 | ($urandom & 32'h0000_FFFF);
                5:          a = $urandom;
                6:          a = ($urandom % 2) ? 32'h807F_FFFF : 32'h8080_0000;
                default:    a = ($urandom % 2) ? 32'h8000_0000 : 32'h7FFF_FFFF;
            endcase
            step(($urandom % 5) != 0, $urandom % 2, 2'($urandom), a, $urandom,
                 ($urandom % 10) == 0, $urandom % 2, ($urandom % 3) == 0, $urandom);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule